// File: doc/BRIEF.md
# Lockable Thermal Alarm Control Register

This block is the control core of a temperature monitor. It holds three signed alarm limits (a high limit, a low limit and a critical limit) and one control register. From each new temperature sample it works out whether an alarm condition exists, and it drives an active-low event pin. The pin can follow the condition (comparator mode), or it can latch on a new condition and hold until software clears it (interrupt mode).

Two protection bits guard the configuration. One freezes the critical limit. The other freezes the high and low limits. Either one also freezes the event-control bits. Both bits take effect from a single write, and once set they stay set until power-on reset. Software reaches the limits and the control register through a plain address/data write port and a combinational read port. The serial bus front end and the temperature converter sit outside this block.

Temperatures and limits are two's-complement values with an LSB of 0.25 °C and a width of `TEMP_W` bits. The data port has the same width.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge), the control register and all three limits read 0 and `event_n` is high. Register addresses: 0 = control, 1 = high limit, 2 = low limit, 3 = critical limit.
- R2: Control bit 7 is the critical protect bit. Writing 1 sets it in one write, and it then reads 1. Writing 0 never clears it; only reset does. While it is set, writes to address 3 are ignored.
- R3: Control bit 6 is the window protect bit. It is set and cleared in the same way as bit 7. While it is set, writes to addresses 1 and 2 are ignored.
- R4: Control bit 3 (pin enable), bit 2 (critical-only) and bit 0 (mode: 0 comparator, 1 interrupt) are written only while both protect bits are clear. A write that sets a protect bit still applies these bits in that same write.
- R5: Control bit 4 reads 1 exactly while `event_n` is driven low. Writes to bit 4 are ignored. Bit 5 and bit 1 always read 0.
- R6: A window condition is temperature > high limit or temperature < low limit. A critical condition is temperature > critical limit. All comparisons are signed and strict.
- R7: With bit 2 clear, the event is raised on a window or critical condition. With bit 2 set, it is raised only on a critical condition.
- R8: In comparator mode, the event follows the condition of the latest sample. `event_n` changes two clock edges after the edge that takes `temp_vld`.
- R9: In interrupt mode, the event sets when the condition goes from absent to present, and it holds after the condition goes away. Writing control bit 5 = 1 clears it at that write's edge, and it stays clear while the same condition persists. In comparator mode, bit 5 has no effect.
- R10: `event_n` is low only while bit 3 is set and an event is active. Setting bit 3 while an event is active pulls the pin low right after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| addr | input | 2 | Register address |
| wdata | input | TEMP_W | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | TEMP_W | Read data for `addr`, combinational |
| temp | input | TEMP_W | Signed temperature sample, 0.25 °C LSB |
| temp_vld | input | 1 | Sample strobe |
| event_n | output | 1 | Active-low event pin |

## Verification
A register write is visible on `rdata` right after the write edge, so the bench reads back at the falling edge that follows the write. A sample passes through two registers: the comparison flags, then the event state. The bench therefore holds `temp_vld` for one cycle and checks `event_n` at the falling edge after the second rising edge. A clear write or an enable write acts on the pin at its own edge, and the bench checks it at the next falling edge. The bench sweeps every sample value of the default 11-bit width, in both the window/critical mode and the critical-only mode, and computes the expected pin from signed integer comparisons.

// File: rtl/tac_pkg.sv
// Shared definitions for the thermal alarm control block.
// Assumes: two address bits select one of four registers.
package tac_pkg;

    typedef enum logic [1:0] {
        REG_CTL   = 2'd0,
        REG_HIGH  = 2'd1,
        REG_LOW   = 2'd2,
        REG_CRIT  = 2'd3
    } reg_addr_e;

    // control register bit positions
    localparam int B_CRIT_PROT = 7;
    localparam int B_WIN_PROT  = 6;
    localparam int B_CLEAR     = 5;
    localparam int B_STATUS    = 4;
    localparam int B_PIN_EN    = 3;
    localparam int B_CRIT_ONLY = 2;
    localparam int B_MODE      = 0;

    typedef struct packed {
        logic pin_en;
        logic crit_only;
        logic irq_mode;
    } evt_ctl_t;

endpackage

// File: rtl/tac_cfg_regs.sv
// Control register and the three alarm limits, with sticky protect bits.
// Assumes: TEMP_W >= 8 so the control byte fits the data port; reset is power-on.
module tac_cfg_regs
    import tac_pkg::*;
#(
    parameter int TEMP_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               addr,
    input  logic [TEMP_W-1:0]        wdata,
    input  logic                     wr_en,
    output logic                     crit_prot,
    output logic                     win_prot,
    output evt_ctl_t                 ctl,
    output logic                     clr_req,
    output logic signed [TEMP_W-1:0] lim_high,
    output logic signed [TEMP_W-1:0] lim_low,
    output logic signed [TEMP_W-1:0] lim_crit
);

    localparam int N_LIM = 3;

    logic     crit_prot_q, win_prot_q;
    evt_ctl_t ctl_q;
    logic     ctl_wr;
    logic     any_prot;
    logic signed [TEMP_W-1:0] lim_q [N_LIM];

    assign ctl_wr   = wr_en && (addr == REG_CTL);
    assign any_prot = crit_prot_q || win_prot_q;

    // Protect bits are set-only; control bits are writable while unprotected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_prot_q <= 1'b0;
            win_prot_q  <= 1'b0;
            ctl_q       <= '0;
        end else if (ctl_wr) begin
            if (wdata[B_CRIT_PROT]) crit_prot_q <= 1'b1;
            if (wdata[B_WIN_PROT])  win_prot_q  <= 1'b1;
            if (!any_prot) begin
                ctl_q.pin_en    <= wdata[B_PIN_EN];
                ctl_q.crit_only <= wdata[B_CRIT_ONLY];
                ctl_q.irq_mode  <= wdata[B_MODE];
            end
        end
    end

    // One limit register per address 1..3; index 2 is the critical limit.
    for (genvar i = 0; i < N_LIM; i++) begin : g_lim
        localparam logic [1:0] MY_ADDR = 2'(i + 1);
        logic locked;
        assign locked = (i == N_LIM - 1) ? crit_prot_q : win_prot_q;

        // Load the limit on an unprotected write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lim_q[i] <= '0;
            else if (wr_en && (addr == MY_ADDR) && !locked)
                lim_q[i] <= $signed(wdata);
        end
    end

    assign crit_prot = crit_prot_q;
    assign win_prot  = win_prot_q;
    assign ctl       = ctl_q;
    assign clr_req   = ctl_wr && wdata[B_CLEAR];
    assign lim_high  = lim_q[0];
    assign lim_low   = lim_q[1];
    assign lim_crit  = lim_q[2];

    a_r2_crit_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        crit_prot_q |=> crit_prot_q);
    a_r2_crit_lim_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        crit_prot_q |=> $stable(lim_crit));
    a_r3_win_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        win_prot_q |=> win_prot_q);
    a_r3_win_lims_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        win_prot_q |=> ($stable(lim_high) && $stable(lim_low)));
    a_r4_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_prot_q || win_prot_q) |=> $stable(ctl));

endmodule

// File: rtl/tac_compare.sv
// Registers the window and critical flags for each valid temperature sample.
// Assumes: signed two's-complement operands of equal width; flags hold between samples.
module tac_compare #(
    parameter int TEMP_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp,
    input  logic                     temp_vld,
    input  logic signed [TEMP_W-1:0] lim_high,
    input  logic signed [TEMP_W-1:0] lim_low,
    input  logic signed [TEMP_W-1:0] lim_crit,
    output logic                     win_hit,
    output logic                     crit_hit
);

    // Strict signed comparisons, captured on the sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_hit  <= 1'b0;
            crit_hit <= 1'b0;
        end else if (temp_vld) begin
            win_hit  <= (temp > lim_high) || (temp < lim_low);
            crit_hit <= (temp > lim_crit);
        end
    end

    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_vld |=> ($stable(win_hit) && $stable(crit_hit)));

endmodule

// File: rtl/tac_event.sv
// Event state: follows the condition in comparator mode, latches on a rising condition in interrupt mode.
// Assumes: clr_req is a single-cycle write strobe from the control register.
module tac_event
    import tac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     win_hit,
    input  logic     crit_hit,
    input  evt_ctl_t ctl,
    input  logic     clr_req,
    output logic     evt_active
);

    logic cond, cond_q, evt_q;

    assign cond = ctl.crit_only ? crit_hit : (win_hit || crit_hit);

    // Track the previous condition and update the event per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            cond_q <= cond;
            if (!ctl.irq_mode)
                evt_q <= cond;
            else if (clr_req)
                evt_q <= 1'b0;
            else if (cond && !cond_q)
                evt_q <= 1'b1;
        end
    end

    assign evt_active = evt_q;

    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.irq_mode && clr_req) |=> !evt_q);
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.irq_mode && evt_q && !clr_req) |=> evt_q);
    a_r8_cmp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.irq_mode && !win_hit && !crit_hit) |=> !evt_q);

endmodule

// File: rtl/thermal_alarm_ctrl.sv
// Top: register file, sample comparison, event state and the active-low pin.
// Assumes: TEMP_W >= 8; rdata is a combinational read of addr.
module thermal_alarm_ctrl
    import tac_pkg::*;
#(
    parameter int TEMP_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               addr,
    input  logic [TEMP_W-1:0]        wdata,
    input  logic                     wr_en,
    output logic [TEMP_W-1:0]        rdata,
    input  logic signed [TEMP_W-1:0] temp,
    input  logic                     temp_vld,
    output logic                     event_n
);

    localparam int PAD_W = TEMP_W - 8;

    logic     crit_prot, win_prot, clr_req;
    evt_ctl_t ctl;
    logic signed [TEMP_W-1:0] lim_high, lim_low, lim_crit;
    logic     win_hit, crit_hit, evt_active, pin_on;
    logic [7:0] ctl_byte;

    tac_cfg_regs #(.TEMP_W(TEMP_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .crit_prot(crit_prot), .win_prot(win_prot), .ctl(ctl), .clr_req(clr_req),
        .lim_high(lim_high), .lim_low(lim_low), .lim_crit(lim_crit)
    );

    tac_compare #(.TEMP_W(TEMP_W)) cmp_i (
        .clk(clk), .rst_n(rst_n), .temp(temp), .temp_vld(temp_vld),
        .lim_high(lim_high), .lim_low(lim_low), .lim_crit(lim_crit),
        .win_hit(win_hit), .crit_hit(crit_hit)
    );

    tac_event evt_i (
        .clk(clk), .rst_n(rst_n), .win_hit(win_hit), .crit_hit(crit_hit),
        .ctl(ctl), .clr_req(clr_req), .evt_active(evt_active)
    );

    assign pin_on  = ctl.pin_en && evt_active;
    assign event_n = !pin_on;

    assign ctl_byte = {crit_prot, win_prot, 1'b0, pin_on,
                       ctl.pin_en, ctl.crit_only, 1'b0, ctl.irq_mode};

    // Combinational read mux over the four registers.
    always_comb begin
        unique case (reg_addr_e'(addr))
            REG_CTL:  rdata = {{PAD_W{1'b0}}, ctl_byte};
            REG_HIGH: rdata = lim_high;
            REG_LOW:  rdata = lim_low;
            default:  rdata = lim_crit;
        endcase
    end

    a_r10_pin_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !event_n |-> (ctl.pin_en && evt_active));
    a_r5_status_tracks_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CTL) |-> (rdata[B_STATUS] == !event_n));

endmodule

// File: tb/thermal_alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module thermal_alarm_ctrl_tb_top;

    localparam int TW = 11;
    localparam int C_EN = 8, C_CO = 4, C_IRQ = 1, C_CLR = 32, C_CP = 128, C_WP = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic [TW-1:0] wdata = '0;
    logic wr_en = 1'b0;
    logic [TW-1:0] rdata;
    logic signed [TW-1:0] temp = '0;
    logic temp_vld = 1'b0;
    logic event_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    thermal_alarm_ctrl #(.TEMP_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .temp(temp), .temp_vld(temp_vld), .event_n(event_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = a[1:0];
        wdata = d[TW-1:0];
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = a[1:0];
        #1;
        v = int'(rdata);
    endtask

    // one-cycle strobe; returns at the falling edge after the second rising edge
    task automatic sample(input int t);
        @(negedge clk);
        temp = t[TW-1:0];
        temp_vld = 1'b1;
        @(negedge clk);
        temp_vld = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int e;

        // R1 reset state
        do_reset();
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            check("R1 reset readback", v, 0);
        end
        check("R1 reset pin", int'(event_n), 1);

        // R5 status and clear bits ignore writes; bit1 reads 0
        wr(0, 16 + 32 + 2);
        rd(0, v);
        check("R5 read-only bits", v, 0);

        // R6 R7 R8 comparator sweep, window or critical
        wr(1, 40); wr(2, -20); wr(3, 300);
        wr(0, C_EN);
        for (int t = -1024; t < 1024; t++) begin
            sample(t);
            e = ((t > 40) || (t < -20) || (t > 300)) ? 0 : 1;
            check("R6 R8 window sweep", int'(event_n), e);
        end
        // R7 critical-only sweep
        wr(0, C_EN + C_CO);
        for (int t = -1024; t < 1024; t++) begin
            sample(t);
            e = (t > 300) ? 0 : 1;
            check("R7 critical-only sweep", int'(event_n), e);
        end
        sample(300);
        check("R6 strict critical boundary", int'(event_n), 1);

        // R9 interrupt mode
        wr(1, 100); wr(2, -100); wr(3, 200);
        wr(0, C_EN + C_IRQ);
        sample(150);
        check("R9 latch on new condition", int'(event_n), 0);
        rd(0, v);
        check("R5 status reads 1 with pin low", v, C_EN + C_IRQ + 16);
        sample(0);
        check("R9 hold after condition ends", int'(event_n), 0);
        wr(0, C_EN + C_IRQ + C_CLR);
        check("R9 clear write", int'(event_n), 1);
        rd(0, v);
        check("R5 clear bit reads 0", v, C_EN + C_IRQ);
        sample(150);
        check("R9 relatch", int'(event_n), 0);
        wr(0, C_EN + C_IRQ + C_CLR);
        sample(160);
        check("R9 no relatch while condition persists", int'(event_n), 1);
        sample(-150);
        check("R9 low-side stays present, no new edge", int'(event_n), 1);
        sample(0);
        sample(-150);
        check("R9 latch on below-low", int'(event_n), 0);

        // R9 clear ignored in comparator mode
        wr(0, C_EN);
        sample(150);
        wr(0, C_EN + C_CLR);
        check("R9 clear no effect in comparator", int'(event_n), 0);
        sample(0);
        check("R8 comparator releases", int'(event_n), 1);

        // R10 pin enable gating
        wr(0, 0);
        sample(150);
        check("R10 disabled pin stays high", int'(event_n), 1);
        rd(0, v);
        check("R5 status 0 while pin disabled", v, 0);
        wr(0, C_EN);
        check("R10 enable pulls pin low", int'(event_n), 0);

        // R2 R3 R4 protect bits
        do_reset();
        wr(1, 100); wr(3, 200);
        wr(0, C_CP);
        rd(0, v);
        check("R2 critical protect reads 1", v, C_CP);
        wr(3, 50);
        rd(3, v);
        check("R2 critical limit frozen", v, 200);
        wr(1, 77);
        rd(1, v);
        check("R3 high limit writable without window protect", v, 77);
        wr(0, C_EN + C_CO + C_IRQ);
        rd(0, v);
        check("R4 control frozen, R2 protect not cleared", v, C_CP);
        wr(0, C_WP);
        rd(0, v);
        check("R3 window protect set", v, C_CP + C_WP);
        wr(2, 5);
        rd(2, v);
        check("R3 low limit frozen", v, 0);
        do_reset();
        rd(0, v);
        check("R1 R2 reset clears protects", v, 0);
        rd(3, v);
        check("R1 reset clears critical limit", v, 0);
        wr(0, C_WP + C_EN + C_CO + C_IRQ);
        rd(0, v);
        check("R4 same-write apply", v, C_WP + C_EN + C_CO + C_IRQ);
        wr(3, 33);
        rd(3, v);
        check("R2 critical limit writable under window protect", v, 33);
        wr(1, 9);
        rd(1, v);
        check("R3 high limit frozen", v, 0);
        wr(0, 0);
        rd(0, v);
        check("R4 R3 zero write ignored", v, C_WP + C_EN + C_CO + C_IRQ);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule